// File: doc/BRIEF.md
# Processor Clock Power-State Sequencer

This block follows the low-power clock state of a mobile processor core. It watches six inputs. A one-cycle pulse reports that the core executed its halt instruction. An active-low stop-clock request asks the core to stop its clock. A bus snoop request needs the core clock for a short time. A level reports that the bus clock has been stopped. A one-cycle interrupt pulse wakes the core. A configuration strap is captured while reset is held. From these inputs the block steps through a fixed set of legal transitions. It reports the current state code, a core clock enable and a ready flag.

The strap chooses where a stop-clock request leads: Quick Start when the strap is low at reset, or Stop Grant otherwise. Only one of the two is ever reachable. With the mobile parameter set, Stop Grant and Sleep are unsupported and are never entered. Leaving Deep Sleep starts a wake-latency counter. The counter covers `CLK_MHZ * EXIT_US` clock cycles. Until it expires, ready stays low and the sequencer holds its state. An event that has no legal transition in the current state leaves the state alone and raises an error flag for one cycle.

Top module: `clkstate_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, the outputs show Normal, clock enable 1, ready 1 and error 0.
- R2: The state codes are Normal=0, Stop Grant=1, Auto Halt=2, Quick Start=3, Snoop=4, Sleep=5 and Deep Sleep=6. Code 7 never appears.
- R3: A halt pulse in Normal moves the block to Auto Halt. A wake pulse in Auto Halt moves it back to Normal.
- R4: The strap is captured only while reset is low; a strap value of 0 selects Quick Start. With Quick Start selected, a low stop-clock request in Normal enters Quick Start, and a high request in Quick Start returns to Normal. A strap change after reset has no effect.
- R5: With the mobile parameter set and a strap of 1 at reset, a stop-clock request in Normal is refused: the state stays Normal and the error flag rises. Stop Grant (1) and Sleep (5) are never entered.
- R6: A snoop request in Auto Halt or Quick Start moves the block to Snoop. When the request drops, the block returns to the state it came from.
- R7: In Quick Start, a high bus-clock-stopped input moves the block to Deep Sleep. When that input falls, the block returns to the state that preceded Deep Sleep.
- R8: Ready is low throughout Deep Sleep. It stays low after exit and rises on the `CLK_MHZ*EXIT_US`-th clock edge after the exit edge. While ready is low outside Deep Sleep, inputs cause no transition.
- R9: An illegal event leaves the state unchanged and sets the error flag for one cycle. The illegal events are: a halt pulse outside Normal, and a high bus-clock-stopped input in Normal, Auto Halt or Snoop.
- R10: The core clock enable is 1 only in Normal and Snoop.
- R11: Priorities: in Auto Halt, wake beats snoop. In Quick Start, stop-clock release beats bus-clock-stopped, which beats snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| strap_n_i | input | 1 | Strap; 0 selects Quick Start as the stop-clock target |
| halt_i | input | 1 | Halt-instruction pulse |
| stopclk_n_i | input | 1 | Active-low stop-clock request |
| snoop_i | input | 1 | Bus snoop request (level) |
| busclk_off_i | input | 1 | Bus clock stopped (level) |
| wake_i | input | 1 | Interrupt/wake pulse |
| state_o | output | 3 | Current state code (R2) |
| core_clk_en_o | output | 1 | Core clock enable |
| ready_o | output | 1 | Low during Deep Sleep and the wake latency |
| illegal_o | output | 1 | One-cycle flag for an ignored illegal event |

## Verification
The sequencer is driven through two resets, once with each strap value. This shows that the stop-clock target is set only by the strap captured at reset: the same request is refused with strap 1 and accepted with strap 0. Snoop excursions are entered from both Auto Halt and Quick Start, which shows that each return goes to its own origin. Several inputs are asserted together in the same cycle to show the priority order. A long Deep Sleep exit is sampled one edge before and on the edge where ready should rise, and a stop-clock release held during that window shows that transitions wait for ready.

// File: rtl/clkstate_pkg.sv
package clkstate_pkg;

    typedef enum logic [2:0] {
        CS_NORMAL  = 3'd0,
        CS_STOPGNT = 3'd1,
        CS_AUTOHLT = 3'd2,
        CS_QUICK   = 3'd3,
        CS_SNOOP   = 3'd4,
        CS_SLEEP   = 3'd5,
        CS_DEEP    = 3'd6
    } cs_state_e;

    typedef struct packed {
        cs_state_e state;
        cs_state_e ret;
        logic      illegal;
    } cs_fsm_t;

    typedef struct packed {
        logic strap_n;
    } cs_strap_t;

endpackage

// File: rtl/clkstate_strap.sv
module clkstate_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_n_i,
    output logic quick_sel_o
);
    import clkstate_pkg::*;

    cs_strap_t d, q;

    always_comb begin
        d = q;
        if (!rst_n) begin
            d.strap_n = strap_n_i;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign quick_sel_o = ~q.strap_n;

    // R4
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(q.strap_n));

endmodule

// File: rtl/clkstate_wake_timer.sv
module clkstate_wake_timer #(
    parameter int CLK_MHZ = 125,
    parameter int EXIT_US = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic deep_i,
    output logic rdy_o
);
    localparam int EXIT_CYC = CLK_MHZ * EXIT_US;
    localparam int CNT_W    = $clog2(EXIT_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rdy;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (deep_i) begin
            d.cnt = '0;
            d.rdy = 1'b0;
        end else if (!q.rdy) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(EXIT_CYC - 1)) begin
                d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.rdy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdy_o = q.rdy;

    // R8
    wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rdy) |-> $past(q.cnt) == CNT_W'(EXIT_CYC - 1));

endmodule

// File: rtl/clkstate_fsm.sv
module clkstate_fsm #(
    parameter bit MOBILE = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     quick_sel_i,
    input  logic                     ready_i,
    input  logic                     halt_i,
    input  logic                     stopclk_n_i,
    input  logic                     snoop_i,
    input  logic                     busclk_off_i,
    input  logic                     wake_i,
    output clkstate_pkg::cs_state_e  state_o,
    output logic                     illegal_o
);
    import clkstate_pkg::*;

    cs_fsm_t d, q;
    logic    bad;
    logic    stop_req;

    assign stop_req = ~stopclk_n_i;

    always_comb begin
        unique case (q.state)
            CS_NORMAL:  bad = busclk_off_i ||
                              (stop_req && !halt_i && !quick_sel_i && MOBILE);
            CS_AUTOHLT: bad = halt_i || busclk_off_i;
            CS_SNOOP:   bad = halt_i || busclk_off_i;
            default:    bad = halt_i;
        endcase
    end

    always_comb begin
        d         = q;
        d.illegal = 1'b0;
        if (ready_i || q.state == CS_DEEP) begin
            if (bad) begin
                d.illegal = 1'b1;
            end else begin
                unique case (q.state)
                    CS_NORMAL: begin
                        if (halt_i) begin
                            d.state = CS_AUTOHLT;
                        end else if (stop_req) begin
                            d.state = quick_sel_i ? CS_QUICK : CS_STOPGNT;
                        end
                    end
                    CS_AUTOHLT: begin
                        if (wake_i) begin
                            d.state = CS_NORMAL;
                        end else if (snoop_i) begin
                            d.state = CS_SNOOP;
                            d.ret   = CS_AUTOHLT;
                        end
                    end
                    CS_QUICK: begin
                        if (!stop_req) begin
                            d.state = CS_NORMAL;
                        end else if (busclk_off_i) begin
                            d.state = CS_DEEP;
                            d.ret   = CS_QUICK;
                        end else if (snoop_i) begin
                            d.state = CS_SNOOP;
                            d.ret   = CS_QUICK;
                        end
                    end
                    CS_STOPGNT: begin
                        if (!stop_req) begin
                            d.state = CS_NORMAL;
                        end else if (busclk_off_i && !MOBILE) begin
                            d.state = CS_SLEEP;
                        end else if (snoop_i) begin
                            d.state = CS_SNOOP;
                            d.ret   = CS_STOPGNT;
                        end
                    end
                    CS_SLEEP: begin
                        if (busclk_off_i) begin
                            d.state = CS_DEEP;
                            d.ret   = CS_SLEEP;
                        end else begin
                            d.state = CS_STOPGNT;
                        end
                    end
                    CS_SNOOP: begin
                        if (!snoop_i) begin
                            d.state = q.ret;
                        end
                    end
                    CS_DEEP: begin
                        if (!busclk_off_i) begin
                            d.state = q.ret;
                        end
                    end
                    default: begin
                        d.state = CS_NORMAL;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= CS_NORMAL;
            q.ret     <= CS_NORMAL;
            q.illegal <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o   = q.state;
    assign illegal_o = q.illegal;

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.state != cs_state_e'(3'd7));

    // R5
    no_unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        MOBILE |-> (q.state != CS_STOPGNT && q.state != CS_SLEEP));

    // R9
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.illegal |-> q.state == $past(q.state));

    // R6
    snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == CS_SNOOP && !snoop_i && !halt_i && !busclk_off_i)
        |=> q.state == $past(q.ret));

    // R7
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == CS_DEEP && $past(q.state) != CS_DEEP)
        |-> ($past(q.state) == CS_QUICK || $past(q.state) == CS_SLEEP));

endmodule

// File: rtl/clkstate_seq.sv
module clkstate_seq #(
    parameter int CLK_MHZ = 125,
    parameter int EXIT_US = 30,
    parameter bit MOBILE  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_n_i,
    input  logic       halt_i,
    input  logic       stopclk_n_i,
    input  logic       snoop_i,
    input  logic       busclk_off_i,
    input  logic       wake_i,
    output logic [2:0] state_o,
    output logic       core_clk_en_o,
    output logic       ready_o,
    output logic       illegal_o
);
    import clkstate_pkg::*;

    cs_state_e state_w;
    logic      quick_sel;
    logic      tmr_rdy;
    logic      in_deep;

    clkstate_strap u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_n_i   (strap_n_i),
        .quick_sel_o (quick_sel)
    );

    clkstate_wake_timer #(
        .CLK_MHZ (CLK_MHZ),
        .EXIT_US (EXIT_US)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .deep_i (in_deep),
        .rdy_o  (tmr_rdy)
    );

    clkstate_fsm #(
        .MOBILE (MOBILE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .quick_sel_i  (quick_sel),
        .ready_i      (ready_o),
        .halt_i       (halt_i),
        .stopclk_n_i  (stopclk_n_i),
        .snoop_i      (snoop_i),
        .busclk_off_i (busclk_off_i),
        .wake_i       (wake_i),
        .state_o      (state_w),
        .illegal_o    (illegal_o)
    );

    assign in_deep       = (state_w == CS_DEEP);
    assign ready_o       = tmr_rdy & ~in_deep;
    assign state_o       = state_w;
    assign core_clk_en_o = (state_w == CS_NORMAL) || (state_w == CS_SNOOP);

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !in_deep) |=> state_w == $past(state_w));

endmodule

// File: tb/clkstate_seq_test.sv
module clkstate_seq_test;

    localparam int CLK_MHZ  = 125;
    localparam int EXIT_US  = 30;
    localparam int EXIT_CYC = CLK_MHZ * EXIT_US;

    localparam int ST_N  = 0;
    localparam int ST_AH = 2;
    localparam int ST_QS = 3;
    localparam int ST_SN = 4;
    localparam int ST_DS = 6;

    typedef struct {
        int st;
        bit ck;
        bit rd;
        bit il;
        int req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_n = 1'b1;
    logic       halt = 1'b0;
    logic       stopn = 1'b1;
    logic       snoop = 1'b0;
    logic       busoff = 1'b0;
    logic       wake = 1'b0;
    logic [2:0] state;
    logic       cken;
    logic       rdy;
    logic       ill;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    clkstate_seq #(
        .CLK_MHZ (CLK_MHZ),
        .EXIT_US (EXIT_US),
        .MOBILE  (1'b1)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_n_i     (strap_n),
        .halt_i        (halt),
        .stopclk_n_i   (stopn),
        .snoop_i       (snoop),
        .busclk_off_i  (busoff),
        .wake_i        (wake),
        .state_o       (state),
        .core_clk_en_o (cken),
        .ready_o       (rdy),
        .illegal_o     (ill)
    );

    task automatic step(input bit h, input bit sn, input bit sp, input bit bo,
                        input bit wk, input int st, input bit ck, input bit rd,
                        input bit il, input int req);
        exp_t e;
        @(negedge clk);
        halt = h; stopn = sn; snoop = sp; busoff = bo; wake = wk;
        e.st = st; e.ck = ck; e.rd = rd; e.il = il; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input bit s);
        @(negedge clk);
        rst_n = 1'b0; strap_n = s;
        halt = 0; stopn = 1; snoop = 0; busoff = 0; wake = 0;
        idle(3);
        // R1: outputs during reset
        checks++;
        if (state !== 3'd0 || cken !== 1'b1 || rdy !== 1'b1 || ill !== 1'b0) begin
            fails++;
            $display("FAIL R1: in reset st=%0d ck=%0b rd=%0b il=%0b exp 0 1 1 0",
                     state, cken, rdy, ill);
        end
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (int'(state) != e.st || cken !== e.ck || rdy !== e.rd || ill !== e.il) begin
                fails++;
                $display("FAIL R%0d: st=%0d ck=%0b rd=%0b il=%0b exp st=%0d ck=%0b rd=%0b il=%0b",
                         e.req, state, cken, rdy, ill, e.st, e.ck, e.rd, e.il);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Strap high: Stop Grant target, unsupported on mobile
        do_reset(1'b1);
        step(0,1,0,0,0, ST_N, 1,1,0, 1);   // R1 first cycle
        step(0,0,0,0,0, ST_N, 1,1,1, 5);   // R5 refused
        step(0,1,0,0,0, ST_N, 1,1,0, 5);
        step(1,1,0,0,0, ST_AH,0,1,0, 3);   // R3 R10
        step(1,1,0,0,0, ST_AH,0,1,1, 9);   // R9 halt outside Normal
        step(0,1,1,0,1, ST_N, 1,1,0, 11);  // R11 wake over snoop
        step(1,1,0,0,0, ST_AH,0,1,0, 3);
        step(0,1,1,0,0, ST_SN,1,1,0, 6);   // R6 R10
        step(0,1,1,1,0, ST_SN,1,1,1, 9);   // R9 bus clock off in Snoop
        step(0,1,0,0,0, ST_AH,0,1,0, 6);   // R6 back to origin
        step(0,1,0,0,1, ST_N, 1,1,0, 3);   // R3 wake
        step(0,1,0,1,0, ST_N, 1,1,1, 9);   // R9 bus clock off in Normal
        @(negedge clk); strap_n = 1'b0;
        step(0,0,0,0,0, ST_N, 1,1,1, 4);   // R4 strap change ignored

        // Strap low: Quick Start target
        do_reset(1'b0);
        step(0,1,0,0,0, ST_N, 1,1,0, 1);   // R1
        step(0,0,0,0,0, ST_QS,0,1,0, 4);   // R4 R10
        step(0,0,1,0,0, ST_SN,1,1,0, 6);   // R6
        step(0,0,0,0,0, ST_QS,0,1,0, 6);   // R6 back to Quick Start
        step(1,0,0,0,0, ST_QS,0,1,1, 9);   // R9
        step(0,1,0,1,0, ST_N, 1,1,0, 11);  // R11 release over bus clock off
        step(0,0,0,0,0, ST_QS,0,1,0, 4);
        step(0,0,1,1,0, ST_DS,0,0,0, 7);   // R7 R11 R2
        step(0,0,0,1,0, ST_DS,0,0,0, 8);   // R8
        step(0,0,0,0,0, ST_QS,0,0,0, 7);   // R7 exit edge E0
        step(0,1,0,0,0, ST_QS,0,0,0, 8);   // R8 E1, release held
        idle(EXIT_CYC - 3);
        step(0,1,0,0,0, ST_QS,0,0,0, 8);   // R8 edge EXIT-1
        step(0,1,0,0,0, ST_QS,0,1,0, 8);   // R8 edge EXIT ready rises
        step(0,1,0,0,0, ST_N, 1,1,0, 8);   // R8 held release taken
        step(0,1,0,0,0, ST_N, 1,1,0, 10);  // R10
        idle(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule